// File: doc/BRIEF.md
# Multi-Master Bus Arbitration-Loss Monitor

This block sits beside the master-side controller of a two-wire, multi-master serial bus (I2C). From the synchronized clock and data line levels, the level this master is driving on the data line, and the controller's current phase, it decides whether this master has lost arbitration. When it has, it asserts a sticky lost flag and, in the same cycle, tells the pad logic to release both lines. It then schedules a single-cycle interrupt at the moment set by the kind of loss.

There are two families of loss. The first is a bit mismatch inside a byte: the master releases data high but reads it low on a rising clock edge. Its interrupt waits for the falling clock edge that ends the eighth or the ninth pulse of the byte, as chosen by the wait-timing input. The second family covers the rest: a start, restart or stop that appears on the bus in the middle of a transfer, or a restart or stop attempt that finds the lines held low. Its interrupt waits for the next stop condition on the bus and fires only if stop interrupts are enabled. A loss that happens during the address or extension-code phase also sets a slave flag, because the device must keep listening in case the winning master addresses it. All pins are plain control and status pins; there is no data stream and no handshake.

Top module: `ald_arb_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, lost_o, slave_o, release_o and irq_o are all 0.
- R2: In phases address (1), extension (2), data (3) or ack (4), a rising clock edge (clock low in the previous cycle, high now) with sda_drv_i=1 and sda_i=0 is a loss: release_o is 1 in that same cycle and lost_o is 1 from the next cycle.
- R3: In phases 1 to 4, a start condition (clock high in both cycles, data falling from 1 to 0) is a loss.
- R4: In phases 1 to 4, a stop condition (clock high in both cycles, data rising from 0 to 1) is a loss.
- R5: In the restart-attempt phase (5), data low, clock low, or a stop condition is a loss.
- R6: In the stop-attempt phase (6), sda_drv_i=1 together with the clock high and data low is a loss. The master's own stop edge is not a loss.
- R7: After an R2 loss, irq_o is high for exactly one cycle. That cycle follows the first clock falling edge (clock high, then low) seen while edge_cnt_i >= 8 when wait_ninth_i=0, or >= 9 when wait_ninth_i=1.
- R8: After an R3 to R6 loss, irq_o is high for one cycle, in the cycle after the next stop condition on the bus, and only if stop_irq_en_i=1 at that stop. A stop seen with the enable at 0 drops the pending interrupt. The stop that causes the loss also counts.
- R9: lost_o stays 1 until clear_i is 1 in a cycle. clear_i clears lost_o and slave_o. Further losses while lost_o is 1 start no second interrupt.
- R10: slave_o goes to 1 with lost_o when the loss happens in phase 1 or 2, and stays 0 for losses in other phases.
- R11: Nothing is a loss in idle phase (0). Nothing is a loss while the master itself drives data low (sda_drv_i=0) and reads it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized clock line level |
| sda_i | input | 1 | Synchronized data line level |
| sda_drv_i | input | 1 | Data level this master drives (1 = released) |
| phase_i | input | 3 | Controller phase: 0 idle, 1 address, 2 extension, 3 data, 4 ack, 5 restart attempt, 6 stop attempt |
| edge_cnt_i | input | CNT_W | Index of the current clock pulse within the byte (1 to 9) |
| wait_ninth_i | input | 1 | 0: interrupt on the eighth falling edge; 1: on the ninth |
| stop_irq_en_i | input | 1 | Enables the interrupt raised at a stop condition |
| clear_i | input | 1 | Clears the lost and slave flags |
| lost_o | output | 1 | Sticky arbitration-lost flag |
| slave_o | output | 1 | Loss happened during address or extension phase; keep listening as slave |
| release_o | output | 1 | Release both lines now (same cycle as the loss) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A table drives pairs of line states (one cycle before, one cycle at the point of interest) through every phase. It separates a real bit mismatch from a matching released bit, from a bit the master drives low itself, and from the same edge in idle phase. The same table tells a mid-transfer start or stop apart from steady lines, and an attempt blocked by a low line apart from a clean or own stop. Directed byte sequences then show that the interrupt lands on the eighth or the ninth falling edge as chosen, including a loss in the ack slot. Further directed sequences show that deferred losses wait for a stop and obey the stop enable.

// File: rtl/ald_pkg.sv
`timescale 1ns/1ps
package ald_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ADDR    = 3'd1,
    PH_EXT     = 3'd2,
    PH_DATA    = 3'd3,
    PH_ACK     = 3'd4,
    PH_RESTART = 3'd5,
    PH_STOP    = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    LC_NONE  = 2'd0,
    LC_BYTE  = 2'd1,
    LC_DEFER = 2'd2
  } loss_class_e;

  // Phases in which a byte is moving on the bus.
  function automatic logic is_transfer(input phase_e p);
    return (p == PH_ADDR) || (p == PH_EXT) || (p == PH_DATA) || (p == PH_ACK);
  endfunction

  // Phases in which a loss turns this device into a listening slave.
  function automatic logic is_addressing(input phase_e p);
    return (p == PH_ADDR) || (p == PH_EXT);
  endfunction

endpackage

// File: rtl/ald_bus_cond.sv
`timescale 1ns/1ps
module ald_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  // Previous-cycle line levels; an idle bus is high on both lines.
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  // Data moves while the clock stays high: start/restart when falling, stop when rising.
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/ald_loss_eval.sv
`timescale 1ns/1ps
module ald_loss_eval
  import ald_pkg::*;
(
  input  phase_e      phase_i,
  input  logic        armed_i,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        sda_drv_i,
  input  logic        scl_rise_i,
  input  logic        start_i,
  input  logic        stop_i,
  output logic        loss_o,
  output loss_class_e cls_o
);

  logic bit_miss;
  logic mid_cond;
  logic rs_block;
  logic sp_block;

  always_comb begin
    // Released-high bit read back low on a rising clock edge.
    bit_miss = is_transfer(phase_i) && scl_rise_i && sda_drv_i && !sda_i;
    // Someone else framed the bus while a byte was in flight.
    mid_cond = is_transfer(phase_i) && (start_i || stop_i);
    // Restart attempt: both lines must be high and no stop may appear.
    rs_block = (phase_i == PH_RESTART) && (!sda_i || !scl_i || stop_i);
    // Stop attempt: released data stays low while the clock is high.
    sp_block = (phase_i == PH_STOP) && sda_drv_i && scl_i && !sda_i;

    loss_o = armed_i && (bit_miss || mid_cond || rs_block || sp_block);
    if (!loss_o)       cls_o = LC_NONE;
    else if (bit_miss) cls_o = LC_BYTE;
    else               cls_o = LC_DEFER;
  end

endmodule

// File: rtl/ald_irq_sched.sv
`timescale 1ns/1ps
module ald_irq_sched
  import ald_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int EARLY_EDGE = 8,
  parameter int LATE_EDGE  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             loss_i,
  input  loss_class_e      cls_i,
  input  logic             scl_fall_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] edge_cnt_i,
  input  logic             wait_ninth_i,
  input  logic             stop_en_i,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] EARLY_V = CNT_W'(EARLY_EDGE);
  localparam logic [CNT_W-1:0] LATE_V  = CNT_W'(LATE_EDGE);

  logic             pend_byte_q;
  logic             pend_def_q;
  logic             irq_q;
  logic [CNT_W-1:0] target;
  logic             new_def;
  logic             fire_byte;
  logic             fire_def;

  always_comb begin
    target    = wait_ninth_i ? LATE_V : EARLY_V;
    new_def   = loss_i && (cls_i == LC_DEFER);
    fire_byte = pend_byte_q && scl_fall_i && (edge_cnt_i >= target);
    fire_def  = (pend_def_q || new_def) && stop_i && stop_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_byte_q <= 1'b0;
      pend_def_q  <= 1'b0;
      irq_q       <= 1'b0;
    end else if (clear_i) begin
      pend_byte_q <= 1'b0;
      pend_def_q  <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= fire_byte || fire_def;
      if (fire_byte)
        pend_byte_q <= 1'b0;
      else if (loss_i && (cls_i == LC_BYTE))
        pend_byte_q <= 1'b1;
      // Any stop settles a deferred interrupt, fired or dropped.
      if (stop_i)
        pend_def_q <= 1'b0;
      else if (new_def)
        pend_def_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_irq_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(scl_fall_i || stop_i));

  assert_irq_edge_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(!stop_i)) |-> ($past(edge_cnt_i) >= $past(target)));

  assert_irq_stop_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(!scl_fall_i)) |-> $past(stop_en_i));

endmodule

// File: rtl/ald_arb_monitor.sv
`timescale 1ns/1ps
module ald_arb_monitor
  import ald_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int EARLY_EDGE = 8,
  parameter int LATE_EDGE  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             sda_drv_i,
  input  logic [2:0]       phase_i,
  input  logic [CNT_W-1:0] edge_cnt_i,
  input  logic             wait_ninth_i,
  input  logic             stop_irq_en_i,
  input  logic             clear_i,
  output logic             lost_o,
  output logic             slave_o,
  output logic             release_o,
  output logic             irq_o
);

  localparam int PH_W = $bits(phase_e);

  phase_e      phase;
  logic        scl_rise;
  logic        scl_fall;
  logic        start_det;
  logic        stop_det;
  logic        loss_now;
  loss_class_e loss_cls;
  logic        lost_q;
  logic        slave_q;

  assign phase = phase_e'(phase_i[PH_W-1:0]);

  ald_bus_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  ald_loss_eval u_eval (
    .phase_i    (phase),
    .armed_i    (!lost_q),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_drv_i  (sda_drv_i),
    .scl_rise_i (scl_rise),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .loss_o     (loss_now),
    .cls_o      (loss_cls)
  );

  ald_irq_sched #(
    .CNT_W      (CNT_W),
    .EARLY_EDGE (EARLY_EDGE),
    .LATE_EDGE  (LATE_EDGE)
  ) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .loss_i       (loss_now),
    .cls_i        (loss_cls),
    .scl_fall_i   (scl_fall),
    .stop_i       (stop_det),
    .edge_cnt_i   (edge_cnt_i),
    .wait_ninth_i (wait_ninth_i),
    .stop_en_i    (stop_irq_en_i),
    .irq_o        (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q  <= 1'b0;
      slave_q <= 1'b0;
    end else if (clear_i) begin
      lost_q  <= 1'b0;
      slave_q <= 1'b0;
    end else begin
      if (loss_now) lost_q <= 1'b1;
      if (loss_now && is_addressing(phase)) slave_q <= 1'b1;
    end
  end

  assign lost_o    = lost_q;
  assign slave_o   = slave_q;
  // Lines are let go in the very cycle the loss is seen.
  assign release_o = lost_q || loss_now;

  assert_loss_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o && !clear_i) |=> lost_o);

  assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !clear_i) |=> lost_o);

  assert_slave_needs_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slave_o |-> lost_o);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !lost_o) |=> !lost_o);

endmodule

// File: tb/ald_arb_monitor_tb.sv
`timescale 1ns/1ps
module ald_arb_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_i, sda_i, sda_drv_i;
  logic [2:0] phase_i;
  logic [3:0] edge_cnt_i;
  logic       wait_ninth_i, stop_irq_en_i, clear_i;
  logic       lost_o, slave_o, release_o, irq_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  int  irq_total = 0;
  logic rel_pre;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  ald_arb_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_drv_i(sda_drv_i),
    .phase_i(phase_i), .edge_cnt_i(edge_cnt_i), .wait_ninth_i(wait_ninth_i),
    .stop_irq_en_i(stop_irq_en_i), .clear_i(clear_i), .lost_o(lost_o),
    .slave_o(slave_o), .release_o(release_o), .irq_o(irq_o)
  );

  // Vector: {phase[2:0], drv, scl_before, sda_before, scl_now, sda_now, expect_loss}
  localparam logic [8:0] VEC [0:17] = '{
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive after the falling edge, note release_o before the
  // rising edge, return just after the rising edge.
  task automatic drive(input logic scl, input logic sda, input logic drv,
                       input logic [2:0] ph, input logic [3:0] cnt, input logic clr);
    @(negedge clk);
    scl_i = scl; sda_i = sda; sda_drv_i = drv; phase_i = ph;
    edge_cnt_i = cnt; clear_i = clr;
    #1 rel_pre = release_o;
    @(posedge clk);
    #1;
    if (irq_o) irq_total++;
  endtask

  task automatic pulse(input int k, input logic sda, input logic [2:0] ph);
    drive(1'b0, sda, 1'b1, ph, 4'(k), 1'b0);
    drive(1'b1, sda, 1'b1, ph, 4'(k), 1'b0);
    drive(1'b0, sda, 1'b1, ph, 4'(k), 1'b0);
  endtask

  // Byte of nine pulses with a loss at pulse lk, in phase lph.
  task automatic byte_run(input logic w9, input int lk, input logic [2:0] lph, input int fire_k);
    int base;
    wait_ninth_i = w9;
    drive(1'b0, 1'b1, 1'b1, 3'd0, 4'd1, 1'b1);
    base = irq_total;
    for (int k = 1; k <= 9; k++) begin
      pulse(k, (k == lk) ? 1'b0 : 1'b1, (k == lk) ? lph : 3'd3);
      check(irq_o, (k == fire_k), $sformatf("R7 irq after pulse %0d wait9=%b", k, w9));
      if (k == lk) check(lost_o, 1'b1, "R2 loss on mismatch pulse");
      if (k == lk - 1) check(lost_o, 1'b0, "R2 no loss before mismatch");
    end
    check(irq_total - base == 1, 1'b1, "R9 exactly one interrupt per loss");
  endtask

  initial begin
    rst_n = 1'b0;
    scl_i = 1'b1; sda_i = 1'b1; sda_drv_i = 1'b1; phase_i = 3'd0;
    edge_cnt_i = 4'd1; wait_ninth_i = 1'b0; stop_irq_en_i = 1'b0; clear_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(lost_o, 1'b0, "R1 lost in reset");
    check(slave_o, 1'b0, "R1 slave in reset");
    check(release_o, 1'b0, "R1 release in reset");
    check(irq_o, 1'b0, "R1 irq in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1;
    check(lost_o | slave_o | release_o | irq_o, 1'b0, "R1 outputs after reset");

    // Table walk: one preparing cycle in idle with clear, then the cycle under test.
    for (int i = 0; i < 18; i++) begin
      logic [8:0] v;
      logic [2:0] ph;
      string tag;
      logic exp_slave;
      v  = VEC[i];
      ph = v[8:6];
      if (ph == 3'd0)                    tag = "R11";
      else if (ph == 3'd5)               tag = "R5";
      else if (ph == 3'd6)               tag = "R6";
      else if (v[4] == 1'b0)             tag = v[5] ? "R2" : "R11";
      else                               tag = v[1] ? "R4" : "R3";
      exp_slave = v[0] && (ph == 3'd1 || ph == 3'd2);
      drive(v[4], v[3], v[5], 3'd0, 4'd1, 1'b1);
      check(lost_o, 1'b0, $sformatf("R9 clear before vector %0d", i));
      drive(v[2], v[1], v[5], ph, 4'd1, 1'b0);
      check(rel_pre, v[0], $sformatf("%s release vector %0d", tag, i));
      check(lost_o, v[0], $sformatf("%s lost vector %0d", tag, i));
      check(slave_o, exp_slave, $sformatf("R10 slave vector %0d", i));
    end

    // Byte-boundary interrupt timing.
    byte_run(1'b0, 3, 3'd3, 8);
    byte_run(1'b1, 3, 3'd3, 9);
    byte_run(1'b0, 9, 3'd4, 9);
    byte_run(1'b1, 8, 3'd1, 9);
    check(slave_o, 1'b1, "R10 slave after address loss");

    // Stop mid-transfer with enable set: interrupt right after that stop.
    stop_irq_en_i = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 3'd0, 4'd1, 1'b1);
    check(lost_o, 1'b0, "R9 clear");
    check(slave_o, 1'b0, "R9 clear slave");
    drive(1'b1, 1'b0, 1'b0, 3'd3, 4'd1, 1'b0);
    check(lost_o, 1'b0, "R11 own low bit");
    drive(1'b1, 1'b1, 1'b1, 3'd3, 4'd1, 1'b0);
    check(lost_o, 1'b1, "R4 stop mid-transfer");
    check(irq_o, 1'b1, "R8 irq at causing stop");
    drive(1'b1, 1'b1, 1'b1, 3'd0, 4'd1, 1'b0);
    check(irq_o, 1'b0, "R8 irq single cycle");

    // Restart mid-transfer: interrupt waits for a later stop.
    drive(1'b0, 1'b1, 1'b1, 3'd0, 4'd1, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 3'd3, 4'd1, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 3'd3, 4'd1, 1'b0);
    check(lost_o, 1'b1, "R3 restart mid-transfer");
    check(irq_o, 1'b0, "R8 no irq before stop");
    drive(1'b0, 1'b0, 1'b1, 3'd0, 4'd1, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 3'd0, 4'd1, 1'b0);
    check(irq_o, 1'b0, "R8 no irq without stop");
    drive(1'b1, 1'b1, 1'b1, 3'd0, 4'd1, 1'b0);
    check(irq_o, 1'b1, "R8 irq on later stop");

    // Enable off at the stop: pending interrupt is dropped.
    stop_irq_en_i = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 3'd0, 4'd1, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 3'd3, 4'd1, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 3'd3, 4'd1, 1'b0);
    check(lost_o, 1'b1, "R4 stop mid-transfer, enable off");
    check(irq_o, 1'b0, "R8 no irq with enable off");
    stop_irq_en_i = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 3'd0, 4'd1, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 3'd0, 4'd1, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 3'd0, 4'd1, 1'b0);
    check(irq_o, 1'b0, "R8 dropped interrupt stays dropped");
    check(lost_o, 1'b1, "R9 flag held without clear");

    // Restart attempt blocked by a stop: fires at that stop.
    drive(1'b1, 1'b0, 1'b1, 3'd0, 4'd1, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 3'd5, 4'd1, 1'b0);
    check(lost_o, 1'b1, "R5 stop during restart attempt");
    check(irq_o, 1'b1, "R8 irq for restart-attempt loss");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule